// File: doc/BRIEF.md
# Two-Channel Timer with Debug-Break Freeze

This block is a 16-bit up-counting timer. A divide-by-2^n prescaler paces the count, and a software-written modulo limit sets where the count wraps. There are two channels. Each channel works either as an input capture, which latches the count on a selected pin edge, or as an output compare, which acts on its pin when the count matches its value. Channel 0 can also run its compare buffered, so that a new value takes effect at the next overflow. In that mode it can produce an edge-aligned PWM waveform.

A debug break input freezes the count and the prescaler, and it blocks captures. A second input decides whether software may clear status flags while the break is active. Every flag clears in two steps: software reads the register while the flag is set, then writes 0 to the flag bit. With the clear-enable input low, a first step taken before the break survives the break. The second step taken afterwards then completes the clear.

Software reaches the timer through a simple strobe-based register bus with combinational read data. The seven registers sit at word addresses 0 to 6: control/status, counter, modulo, then control and value for channel 0, then control and value for channel 1.

Top module: `tmr2ch_break`

## Requirements
- R1: After reset, control/status (address 0) reads 0, modulo (address 2) reads 0xFFFF, both channel pins and output enables are 0, and the interrupt is low.
- R2: The control field [2:0] selects the prescaler: a value n of 0 to 6 gives one counter tick every 2^n clocks, and 7 gives one every 64. The counter at address 1 advances by one on each tick.
- R3: On a tick with the counter equal to the modulo register, the counter wraps to 0 and control bit 7 (overflow flag) sets. The interrupt is high while bit 7 and bit 6 (enable) are both 1.
- R4: Control bit 5 = 1 stops the counter. Writing 1 to bit 4 clears the counter and the prescaler, and bit 4 always reads back 0.
- R5: A flag clears only when a bus read of its register while the flag is 1 is followed by a write with the flag bit (bit 7) at 0. A write alone leaves the flag set. A new set event between the two steps cancels the pending clear.
- R6: While the break input is 1, the counter and prescaler hold their values, and counting resumes from the held value once the break ends.
- R7: While the break input is 1, no capture is recorded: the channel value and flag stay unchanged, including for an edge that occurred during the break after the break ends.
- R8: With break active and clear-enable 0, reads and writes leave every flag unchanged. A read taken before the break still counts as the first step, so a write of 0 after the break clears the flag.
- R9: With break active and clear-enable 1, the two-step clear works, and the cleared flag stays 0 after the break.
- R10: With channel control bit 4 = 0 (capture), bits [1:0] select the edge (01 rising, 10 falling, 11 both). A selected edge on the pin latches the current count into the channel value register and sets channel bit 7.
- R11: With channel bit 4 = 1 (compare), the pin output is enabled. On a tick where the count equals the channel value, the channel flag sets and bits [1:0] act on the pin (00 none, 01 toggle, 10 drive 0, 11 drive 1).
- R12: On channel 0 in compare mode, bit 5 (buffered) or bit 3 (PWM) makes value writes take effect only at the next overflow, and reads return the active value. In PWM mode the pin goes 1 at overflow and 0 at a match, and overflow wins when both happen on the same tick. Channel 1 ignores bits 5 and 3, which read back 0.
- R13: The interrupt is also high while any channel flag and its channel bit 6 (enable) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| brk_i | input | 1 | Debug break: freeze counter, block captures |
| brk_clr_en_i | input | 1 | Allow flag clearing during break |
| bus_addr_i | input | 3 | Register word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (first step of a flag clear) |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational on address |
| ch_pin_i | input | 2 | Channel capture inputs |
| ch_pin_o | output | 2 | Channel compare outputs |
| ch_oe_o | output | 2 | Channel output enables (compare mode) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong prescaler or counter state shows on the counter register within one tick period, and a wrong wrap shows on the overflow flag one tick after the count reaches the modulo limit. A lost or stale clear-arm bit shows only at the second clear step: the flag stays set when it should drop, or drops without a preceding read. For this reason the bench brackets the break with reads and writes on both sides. Buffered-compare errors show at the first PWM period after a value write: the pin falls at the old match point instead of the new one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_CNT   = 3'd1;
  localparam logic [AW-1:0] A_MOD   = 3'd2;
  localparam logic [AW-1:0] A_C0CTL = 3'd3;
  localparam logic [AW-1:0] A_C0VAL = 3'd4;
  localparam logic [AW-1:0] A_C1CTL = 3'd5;
  localparam logic [AW-1:0] A_C1VAL = 3'd6;

  // shared bit positions in control registers
  localparam int unsigned B_FLAG = 7;
  localparam int unsigned B_IE   = 6;
  // timer control
  localparam int unsigned B_STOP = 5;
  localparam int unsigned B_CRST = 4;
  // channel control
  localparam int unsigned B_BUF  = 5;
  localparam int unsigned B_OC   = 4;
  localparam int unsigned B_PWM  = 3;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_LOW  = 2'b10,
    ACT_HIGH = 2'b11
  } oc_act_e;
endpackage

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr0_i,
  input  logic frz_i,
  output logic flag_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;
    end else if (!frz_i) begin
      if (wr0_i && arm_q) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (rd_i && flag_q) begin
        arm_q  <= 1'b1;
      end
    end
  end

  assign flag_o = flag_q;

  a_r8_frozen_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frz_i && !set_i) |=> ($stable(flag_q) && $stable(arm_q)));
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (flag_q && !arm_q));
  a_r5_no_clear_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !arm_q) |=> flag_q);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned PRE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(sel_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (run_i)  pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  a_r6_hold_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic [W-1:0] mod_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = tick_i && (cnt_q == mod_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ovf_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (cnt_q == mod_i)) |=> (cnt_q == '0));
  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !clr_i && (cnt_q != mod_i)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r4_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned W      = 16,
  parameter bit          BUF_OK = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ovf_i,
  input  logic [W-1:0] cnt_i,
  input  logic         brk_i,
  input  logic         frz_i,
  input  logic         pin_i,
  input  logic         ctl_wr_i,
  input  logic         ctl_rd_i,
  input  logic         val_wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [7:0]   ctl_o,
  output logic [W-1:0] val_o,
  output logic         pin_o,
  output logic         oe_o,
  output logic         irq_o
);
  logic         ie_q, buf_q, oc_q, pwm_q;
  logic [1:0]   sel_q;
  logic         s1_q, s2_q, prev_q;
  logic [W-1:0] val_q, pend_q;
  logic         pend_v_q, pin_q, flag;
  logic         rise, fall, cap, match, buffered, pwm_on;
  logic         unused_w;

  assign unused_w = wdata_i[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0; buf_q <= 1'b0; oc_q <= 1'b0; pwm_q <= 1'b0; sel_q <= 2'b00;
    end else if (ctl_wr_i) begin
      ie_q  <= wdata_i[B_IE];
      buf_q <= BUF_OK & wdata_i[B_BUF];
      oc_q  <= wdata_i[B_OC];
      pwm_q <= BUF_OK & wdata_i[B_PWM];
      sel_q <= wdata_i[1:0];
    end
  end

  // input synchronizer and edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0; s2_q <= 1'b0; prev_q <= 1'b0;
    end else begin
      s1_q <= pin_i; s2_q <= s1_q; prev_q <= s2_q;
    end
  end

  assign rise     = s2_q & ~prev_q;
  assign fall     = ~s2_q & prev_q;
  assign cap      = !oc_q && !brk_i && ((sel_q[0] && rise) || (sel_q[1] && fall));
  assign match    = oc_q && tick_i && (cnt_i == val_q);
  assign buffered = BUF_OK && oc_q && (buf_q || pwm_q);
  assign pwm_on   = BUF_OK && oc_q && pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0; pend_q <= '0; pend_v_q <= 1'b0;
    end else begin
      if (cap) begin
        val_q <= cnt_i;
      end else begin
        if (buffered && ovf_i && pend_v_q) begin
          val_q    <= pend_q;
          pend_v_q <= 1'b0;
        end
        if (val_wr_i) begin
          if (buffered) begin
            pend_q   <= wdata_i;
            pend_v_q <= 1'b1;
          end else begin
            val_q    <= wdata_i;
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (pwm_on) begin
      if (ovf_i)      pin_q <= 1'b1;
      else if (match) pin_q <= 1'b0;
    end else if (match) begin
      unique case (oc_act_e'(sel_q))
        ACT_TOG:  pin_q <= ~pin_q;
        ACT_LOW:  pin_q <= 1'b0;
        ACT_HIGH: pin_q <= 1'b1;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  tmr_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cap | match),
    .rd_i   (ctl_rd_i),
    .wr0_i  (ctl_wr_i && !wdata_i[B_FLAG]),
    .frz_i  (frz_i),
    .flag_o (flag)
  );

  assign ctl_o = {flag, ie_q, buf_q, oc_q, pwm_q, 1'b0, sel_q};
  assign val_o = val_q;
  assign pin_o = pin_q;
  assign oe_o  = oc_q;
  assign irq_o = flag & ie_q;

  a_r10_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap |=> (flag && (val_q == $past(cnt_i))));
  a_r7_no_capture_in_break: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !val_wr_i) |=> $stable(val_q));
  a_r12_pwm_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && pwm_on) |=> pin_q);
  a_r11_match_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match |=> flag);
endmodule

// File: rtl/tmr2ch_break.sv
module tmr2ch_break
  import tmr_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned SEL_W = 3,
  parameter int unsigned PRE_W = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          brk_i,
  input  logic          brk_clr_en_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [W-1:0]  bus_wdata_i,
  output logic [W-1:0]  bus_rdata_o,
  input  logic [1:0]    ch_pin_i,
  output logic [1:0]    ch_pin_o,
  output logic [1:0]    ch_oe_o,
  output logic          irq_o
);
  localparam int unsigned NCH = 2;

  logic             ie_q, stop_q;
  logic [SEL_W-1:0] ps_q;
  logic [W-1:0]     mod_q, cnt;
  logic             frz, run, tick, ovf, cnt_clr, ovf_flag;
  logic             wr_ctrl, rd_ctrl;
  logic             unused_bits;
  logic [7:0]       ch_ctl [NCH];
  logic [W-1:0]     ch_val [NCH];
  logic [NCH-1:0]   ch_irq;

  assign unused_bits = ^{bus_wdata_i[W-1:8], bus_wdata_i[3]};

  assign frz     = brk_i && !brk_clr_en_i;
  assign run     = !stop_q && !brk_i;
  assign wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
  assign rd_ctrl = bus_rd_i && (bus_addr_i == A_CTRL);
  assign cnt_clr = wr_ctrl && bus_wdata_i[B_CRST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q <= 1'b0; stop_q <= 1'b0; ps_q <= '0;
    end else if (wr_ctrl) begin
      ie_q   <= bus_wdata_i[B_IE];
      stop_q <= bus_wdata_i[B_STOP];
      ps_q   <= bus_wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mod_q <= '1;
    else if (bus_wr_i && (bus_addr_i == A_MOD)) mod_q <= bus_wdata_i;
  end

  tmr_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .clr_i  (cnt_clr),
    .sel_i  (ps_q),
    .tick_o (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (cnt_clr),
    .mod_i  (mod_q),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  tmr_flag u_ovf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ovf),
    .rd_i   (rd_ctrl),
    .wr0_i  (wr_ctrl && !bus_wdata_i[B_FLAG]),
    .frz_i  (frz),
    .flag_o (ovf_flag)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [AW-1:0] A_CTL = (g == 0) ? A_C0CTL : A_C1CTL;
    localparam logic [AW-1:0] A_VAL = (g == 0) ? A_C0VAL : A_C1VAL;
    tmr_channel #(.W(W), .BUF_OK(g == 0)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .ovf_i    (ovf),
      .cnt_i    (cnt),
      .brk_i    (brk_i),
      .frz_i    (frz),
      .pin_i    (ch_pin_i[g]),
      .ctl_wr_i (bus_wr_i && (bus_addr_i == A_CTL)),
      .ctl_rd_i (bus_rd_i && (bus_addr_i == A_CTL)),
      .val_wr_i (bus_wr_i && (bus_addr_i == A_VAL)),
      .wdata_i  (bus_wdata_i),
      .ctl_o    (ch_ctl[g]),
      .val_o    (ch_val[g]),
      .pin_o    (ch_pin_o[g]),
      .oe_o     (ch_oe_o[g]),
      .irq_o    (ch_irq[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      A_CTRL:  bus_rdata_o[7:0] = {ovf_flag, ie_q, stop_q, 1'b0, 1'b0, ps_q};
      A_CNT:   bus_rdata_o = cnt;
      A_MOD:   bus_rdata_o = mod_q;
      A_C0CTL: bus_rdata_o[7:0] = ch_ctl[0];
      A_C0VAL: bus_rdata_o = ch_val[0];
      A_C1CTL: bus_rdata_o[7:0] = ch_ctl[1];
      A_C1VAL: bus_rdata_o = ch_val[1];
      default: bus_rdata_o = '0;
    endcase
  end

  assign irq_o = (ovf_flag & ie_q) | (|ch_irq);

  a_r6_counter_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !cnt_clr) |=> $stable(cnt));
  a_r4_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !cnt_clr && !wr_ctrl) |=> $stable(cnt));
  a_r3_irq_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ovf_flag || (|ch_irq)));
endmodule

// File: tb/test_tmr2ch_break.sv
module test_tmr2ch_break;
  localparam logic [2:0] CTRL = 3'd0, CNT = 3'd1, MODR = 3'd2,
                         C0CTL = 3'd3, C0VAL = 3'd4, C1CTL = 3'd5, C1VAL = 3'd6;
  localparam int NV = 8;
  // {prescale, modulo, edges after counter reset, expected count}
  localparam logic [50:0] VEC [NV] = '{
    {3'd0, 16'hFFFF, 16'd10,  16'd10},
    {3'd1, 16'hFFFF, 16'd10,  16'd5},
    {3'd2, 16'hFFFF, 16'd13,  16'd3},
    {3'd3, 16'hFFFF, 16'd40,  16'd5},
    {3'd6, 16'hFFFF, 16'd200, 16'd3},
    {3'd7, 16'hFFFF, 16'd130, 16'd2},
    {3'd0, 16'd4,    16'd7,   16'd2},
    {3'd1, 16'd3,    16'd20,  16'd2}
  };

  logic clk = 1'b0, rst_n = 1'b0, brk = 1'b0, bcfe = 1'b0;
  logic [2:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic [1:0] pin_in = '0, pin_out, oe;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [15:0] a, b, c;

  always #5 clk = ~clk;

  tmr2ch_break i_tmr2ch_break (
    .clk_i(clk), .rst_ni(rst_n), .brk_i(brk), .brk_clr_en_i(bcfe),
    .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .ch_pin_i(pin_in), .ch_pin_o(pin_out),
    .ch_oe_o(oe), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic bus_wr(input logic [2:0] ad, input logic [15:0] d);
    addr = ad; wdata = d; wr = 1'b1;
    @(posedge clk); @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] ad, output logic [15:0] d);
    addr = ad; rd = 1'b1; #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] ad, output logic [15:0] d);
    addr = ad; #1 d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] d;
    wait_n(2);
    rst_n = 1'b1;
    wait_n(1);

    // R1 reset state
    peek(CTRL, d);  chk("R1 ctrl", d, 16'h0000);
    peek(MODR, d);  chk("R1 modulo", d, 16'hFFFF);
    chk("R1 pins", {12'd0, pin_out, oe}, 16'h0000);
    chk("R1 irq", {15'd0, irq}, 16'h0000);

    // R2 prescaler / modulo vectors
    for (int i = 0; i < NV; i++) begin
      bus_wr(MODR, VEC[i][47:32]);
      bus_wr(CTRL, 16'h0010 | {13'd0, VEC[i][50:48]});
      wait_n(int'(VEC[i][31:16]));
      peek(CNT, d);
      chk($sformatf("R2 vector %0d", i), d, VEC[i][15:0]);
    end

    // R4 reset bit reads 0, stop holds counter
    peek(CTRL, d); chk("R4 reset bit reads 0", d & 16'h007F, 16'h0001);
    bus_wr(CTRL, 16'h0020);
    peek(CNT, a); wait_n(10); peek(CNT, b);
    chk("R4 stop holds count", b, a);

    // R3 overflow flag and interrupt
    bus_wr(MODR, 16'd3);
    bus_rd(CTRL, d);
    bus_wr(CTRL, 16'h0020);
    peek(CTRL, d); chk("R5 flag cleared by read+write", d & 16'h0080, 16'h0000);
    bus_wr(CTRL, 16'h0010);
    wait_n(3); peek(CTRL, d); chk("R3 flag not yet", d & 16'h0080, 16'h0000);
    wait_n(1); peek(CTRL, d); chk("R3 flag on wrap", d & 16'h0080, 16'h0080);
    chk("R3 irq masked", {15'd0, irq}, 16'h0000);
    bus_wr(CTRL, 16'h0060);
    peek(CTRL, d); chk("R5 write alone keeps flag", d & 16'h0080, 16'h0080);
    chk("R3 irq enabled", {15'd0, irq}, 16'h0001);

    // R5 two-step clear
    bus_rd(CTRL, d);
    bus_wr(CTRL, 16'h0020);
    peek(CTRL, d); chk("R5 two-step clear", d & 16'h0080, 16'h0000);
    chk("R5 irq drops", {15'd0, irq}, 16'h0000);

    // R5 set between steps cancels clear
    bus_wr(CTRL, 16'h0010);
    wait_n(6);
    bus_rd(CTRL, d);
    wait_n(4);
    bus_wr(CTRL, 16'h0020);
    peek(CTRL, d); chk("R5 re-set between steps", d & 16'h0080, 16'h0080);

    // R8 break with clear-enable 0
    bus_rd(CTRL, d);
    brk = 1'b1; bcfe = 1'b0;
    bus_wr(CTRL, 16'h0020);
    peek(CTRL, d); chk("R8 flag held in break", d & 16'h0080, 16'h0080);
    bus_rd(CTRL, d);
    brk = 1'b0;
    bus_wr(CTRL, 16'h0020);
    peek(CTRL, d); chk("R8 second step after break", d & 16'h0080, 16'h0000);

    // R9 break with clear-enable 1
    bus_wr(CTRL, 16'h0010);
    wait_n(6);
    bus_wr(CTRL, 16'h0020);
    brk = 1'b1; bcfe = 1'b1;
    bus_rd(CTRL, d);
    bus_wr(CTRL, 16'h0020);
    peek(CTRL, d); chk("R9 cleared in break", d & 16'h0080, 16'h0000);
    brk = 1'b0; bcfe = 1'b0;
    wait_n(2);
    peek(CTRL, d); chk("R9 stays cleared", d & 16'h0080, 16'h0000);

    // R6 break freezes counter
    bus_wr(MODR, 16'hFFFF);
    bus_wr(CTRL, 16'h0010);
    wait_n(3);
    brk = 1'b1;
    peek(CNT, a); wait_n(10); peek(CNT, b);
    chk("R6 frozen in break", b, a);
    brk = 1'b0;
    wait_n(5); peek(CNT, c);
    chk("R6 resumes", c, a + 16'd5);

    // R11 output compare toggle on channel 1
    bus_wr(C1VAL, 16'd5);
    bus_wr(C1CTL, 16'h0011);
    bus_wr(CTRL, 16'h0010);
    wait_n(5);
    chk("R11 pin before match", {14'd0, pin_out[1], oe[1]}, 16'h0001);
    wait_n(1);
    chk("R11 pin toggled", {15'd0, pin_out[1]}, 16'h0001);
    peek(C1CTL, d); chk("R11 match flag", d & 16'h0080, 16'h0080);
    bus_wr(CTRL, 16'h0020);
    bus_rd(C1CTL, d);
    bus_wr(C1CTL, 16'h0000);
    peek(C1CTL, d); chk("R5 channel flag cleared", d, 16'h0000);

    // R12 channel 1 ignores buffered / pwm bits
    bus_wr(C1CTL, 16'h0028);
    peek(C1CTL, d); chk("R12 ch1 ignores bits 5,3", d & 16'h007F, 16'h0000);
    bus_wr(C1CTL, 16'h0000);

    // R10 capture rising edge (counter stopped)
    peek(CNT, a);
    bus_wr(C1CTL, 16'h0001);
    pin_in[1] = 1'b1; wait_n(4);
    peek(C1VAL, d); chk("R10 captured count", d, a);
    peek(C1CTL, d); chk("R10 capture flag", d & 16'h0080, 16'h0080);
    bus_wr(C1CTL, 16'h0041);
    chk("R13 channel irq", {15'd0, irq}, 16'h0001);
    bus_rd(C1CTL, d);
    bus_wr(C1CTL, 16'h0001);
    pin_in[1] = 1'b0; wait_n(4);
    peek(C1CTL, d); chk("R10 falling ignored in rising mode", d & 16'h0080, 16'h0000);
    bus_wr(C1CTL, 16'h0002);
    pin_in[1] = 1'b1; wait_n(4);
    peek(C1CTL, d); chk("R10 rising ignored in falling mode", d & 16'h0080, 16'h0000);
    pin_in[1] = 1'b0; wait_n(4);
    peek(C1CTL, d); chk("R10 falling captured", d & 16'h0080, 16'h0080);

    // R7 break blocks capture
    bus_rd(C1CTL, d);
    bus_wr(C1CTL, 16'h0003);
    bus_wr(C1VAL, 16'h1234);
    brk = 1'b1;
    pin_in[1] = 1'b1; wait_n(5);
    peek(C1VAL, d); chk("R7 value kept in break", d, 16'h1234);
    peek(C1CTL, d); chk("R7 no flag in break", d & 16'h0080, 16'h0000);
    brk = 1'b0; wait_n(4);
    peek(C1CTL, d); chk("R7 no late capture", d & 16'h0080, 16'h0000);

    // R12 buffered PWM on channel 0
    bus_wr(C0CTL, 16'h0000);
    bus_wr(C0VAL, 16'd3);
    bus_wr(MODR, 16'd9);
    bus_wr(C0CTL, 16'h0018);
    bus_wr(CTRL, 16'h0010);
    wait_n(12);
    chk("R12 pwm high after overflow", {15'd0, pin_out[0]}, 16'h0001);
    wait_n(3);
    chk("R12 pwm low after match", {15'd0, pin_out[0]}, 16'h0000);
    bus_wr(C0VAL, 16'd7);
    bus_rd(C0VAL, d); chk("R12 old value still active", d, 16'd3);
    wait_n(8);
    chk("R12 new value not used early", {15'd0, pin_out[0]}, 16'h0001);
    wait_n(4);
    chk("R12 new value after overflow", {15'd0, pin_out[0]}, 16'h0000);

    summary();
  end
endmodule